// File: doc/BRIEF.md
# Isochronous Serial Clock Source Router

This block decides where the bit timing of a serial port comes from and what, if anything, is sent out on the port's two outgoing timing lines. Two timing inputs arrive from the attached equipment (a transmit-side timing lead and a receive-side timing lead). Each is synchronized into the system clock domain and reduced to a one-cycle tick on every rising edge. Two internal baud generators supply their own ticks directly. A 12-bit configuration word, split into four 3-bit fields, picks the tick that paces the transmitter, the tick that paces the receiver, and the source of each outgoing timing line.

Each outgoing timing line is rebuilt as a square wave that flips on every tick of its chosen source, so it runs at half the tick rate. A line that is not configured is held low with its output enable off. A stop-clock request from the flow-control logic silences the outgoing lines, so that equipment timed by them stops sending. Field codes that are not defined fall back to code 0 and raise a configuration-error flag. The all-zero word gives plain asynchronous operation: both directions run from the internal generators and no timing line is driven.

Top module: `iso_clk_router`

## Requirements
- R1: While `rst` is high, and on the first cycle after it, every output is 0.
- R2: `cfg_word[2:0]` selects the transmit tick: 0 the transmit baud generator, 1 the tick from `dce_txt_in`, 2 the tick from `dce_rxt_in`. `tx_tick` is registered; a baud generator tick present at clock edge k shows on `tx_tick` after edge k.
- R3: `cfg_word[5:3]` selects the receive tick with the same codes: 0 the receive baud generator, 1 `dce_txt_in`, 2 `dce_rxt_in`. It drives `rx_tick` with the same timing as R2.
- R4: Each external timing input is passed through a two-flop synchronizer. A low-to-high change first sampled at edge k gives exactly one tick, visible on `tx_tick`/`rx_tick` after edge k+2. A level held high gives no further ticks.
- R5: `cfg_word[8:6]` selects the source of `dte_txt_out`: 0 none, 1 the receive baud generator tick, 2 the transmit baud generator tick, 3 the `dce_txt_in` tick, 4 the `dce_rxt_in` tick. The line toggles after each edge at which its selected tick is present, with the same tick alignment as R2 and R4.
- R6: `cfg_word[11:9]` selects the source of `dte_rxt_out` with the same five codes and the same behaviour as R5.
- R7: A line whose code is 0 is held low and its enable (`dte_txt_oe`/`dte_rxt_oe`) is 0. A line with codes 1 to 4 has its enable at 1 after the next edge.
- R8: While `stop_clk` is high at an edge and at least one line is configured, both lines are 0 after that edge. Their enables are unchanged. Toggling resumes from low once `stop_clk` falls.
- R9: Codes 3 to 7 in the transmit or receive field, and codes 5 to 7 in either line field, act as code 0. `cfg_err` is 1 after any edge at which the word holds such a code, and 0 otherwise.
- R10: With `cfg_word` all zero, `tx_tick` and `rx_tick` follow the internal generators, both lines stay low, both enables stay 0, and `cfg_err` stays 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_word | input | 12 | Four 3-bit routing fields |
| tx_brg_tick | input | 1 | One-cycle tick from the internal transmit baud generator |
| rx_brg_tick | input | 1 | One-cycle tick from the internal receive baud generator |
| dce_txt_in | input | 1 | Asynchronous transmit timing from the attached equipment |
| dce_rxt_in | input | 1 | Asynchronous receive timing from the attached equipment |
| stop_clk | input | 1 | Flow-control request to silence the outgoing timing lines |
| tx_tick | output | 1 | Selected transmit bit tick |
| rx_tick | output | 1 | Selected receive bit tick |
| dte_txt_out | output | 1 | Outgoing transmit timing line |
| dte_txt_oe | output | 1 | Enable for `dte_txt_out` |
| dte_rxt_out | output | 1 | Outgoing receive timing line |
| dte_rxt_oe | output | 1 | Enable for `dte_rxt_out` |
| cfg_err | output | 1 | Undefined field code present |

## Verification
The bench targets the latency gap between internal ticks (one edge) and synchronized external ticks (three edges). A design that mis-counted a synchronizer stage would shift every external tick by a cycle, and its output toggles would slip against the reference. External levels are held high for long stretches: a level detector in place of an edge detector would pour out ticks instead of one. Stop-clock bursts land in the middle of toggling, which catches a design that freezes the line high or drops the enable. Undefined codes in every field catch a design that decodes them to some live source or fails to raise `cfg_err`.

// File: rtl/iso_clk_pkg.sv
`timescale 1ns/1ps
package iso_clk_pkg;
  localparam int FIELD_W = 3;
  localparam int N_FIELDS = 4;
  localparam int CFG_W = FIELD_W * N_FIELDS;

  typedef enum logic [FIELD_W-1:0] {
    CK_INT    = 3'd0,
    CK_DCE_TX = 3'd1,
    CK_DCE_RX = 3'd2
  } clk_src_e;

  typedef enum logic [FIELD_W-1:0] {
    OUT_OFF    = 3'd0,
    OUT_RX_BRG = 3'd1,
    OUT_TX_BRG = 3'd2,
    OUT_DCE_TX = 3'd3,
    OUT_DCE_RX = 3'd4
  } out_src_e;
endpackage

// File: rtl/iso_edge_sync.sv
`timescale 1ns/1ps
module iso_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_in,
  output logic tick
);
  localparam int TOP = STAGES - 1;

  logic [TOP:0] chain;
  logic         last_lvl;

  always_ff @(posedge clk) begin
    if (rst) begin
      chain    <= '0;
      last_lvl <= 1'b0;
    end else begin
      chain    <= {chain[TOP-1:0], async_in};
      last_lvl <= chain[TOP];
    end
  end

  assign tick = chain[TOP] & ~last_lvl;

  // R4
  tick_single_chk: assert property (@(posedge clk) disable iff (rst)
    tick |=> !tick);
endmodule

// File: rtl/iso_cfg_decode.sv
`timescale 1ns/1ps
module iso_cfg_decode
  import iso_clk_pkg::*;
(
  input  logic [CFG_W-1:0] cfg_raw,
  output clk_src_e         dir_sel [2],
  output out_src_e         line_sel [2],
  output logic             bad
);
  logic [1:0] dir_bad;
  logic [1:0] line_bad;

  for (genvar i = 0; i < 2; i++) begin : g_dir
    logic [FIELD_W-1:0] code;
    assign code = cfg_raw[i*FIELD_W +: FIELD_W];
    always_comb begin
      dir_bad[i] = (code > FIELD_W'(CK_DCE_RX));
      dir_sel[i] = dir_bad[i] ? CK_INT : clk_src_e'(code);
    end
  end

  for (genvar j = 0; j < 2; j++) begin : g_line
    logic [FIELD_W-1:0] code;
    assign code = cfg_raw[(j+2)*FIELD_W +: FIELD_W];
    always_comb begin
      line_bad[j] = (code > FIELD_W'(OUT_DCE_RX));
      line_sel[j] = line_bad[j] ? OUT_OFF : out_src_e'(code);
    end
  end

  assign bad = |{dir_bad, line_bad};
endmodule

// File: rtl/iso_timing_line.sv
`timescale 1ns/1ps
module iso_timing_line
  import iso_clk_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  out_src_e src,
  input  logic     rx_brg,
  input  logic     tx_brg,
  input  logic     ext_tx,
  input  logic     ext_rx,
  input  logic     silence,
  output logic     line,
  output logic     oe
);
  logic sel_tick;

  always_comb begin
    case (src)
      OUT_RX_BRG: sel_tick = rx_brg;
      OUT_TX_BRG: sel_tick = tx_brg;
      OUT_DCE_TX: sel_tick = ext_tx;
      OUT_DCE_RX: sel_tick = ext_rx;
      default:    sel_tick = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      line <= 1'b0;
      oe   <= 1'b0;
    end else begin
      oe <= (src != OUT_OFF);
      if (src == OUT_OFF || silence) line <= 1'b0;
      else if (sel_tick)             line <= ~line;
    end
  end

  // R7
  idle_low_chk: assert property (@(posedge clk) disable iff (rst)
    !oe |-> !line);
  // R8
  stop_low_chk: assert property (@(posedge clk) disable iff (rst)
    silence |=> !line);
  // R5
  rise_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(line) |-> $past(sel_tick));
endmodule

// File: rtl/iso_clk_router.sv
`timescale 1ns/1ps
module iso_clk_router
  import iso_clk_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CFG_W-1:0] cfg_word,
  input  logic             tx_brg_tick,
  input  logic             rx_brg_tick,
  input  logic             dce_txt_in,
  input  logic             dce_rxt_in,
  input  logic             stop_clk,
  output logic             tx_tick,
  output logic             rx_tick,
  output logic             dte_txt_out,
  output logic             dte_txt_oe,
  output logic             dte_rxt_out,
  output logic             dte_rxt_oe,
  output logic             cfg_err
);
  localparam int N_EXT = 2;

  clk_src_e   dir_sel [2];
  out_src_e   line_sel [2];
  logic       cfg_bad;
  logic [N_EXT-1:0] ext_in;
  logic [N_EXT-1:0] ext_tick;
  logic [1:0] brg_tick;
  logic [1:0] dir_next;
  logic [1:0] line_q;
  logic [1:0] oe_q;
  logic       silence;

  assign ext_in   = {dce_rxt_in, dce_txt_in};
  assign brg_tick = {rx_brg_tick, tx_brg_tick};

  iso_cfg_decode u_dec (
    .cfg_raw  (cfg_word),
    .dir_sel  (dir_sel),
    .line_sel (line_sel),
    .bad      (cfg_bad)
  );

  for (genvar e = 0; e < N_EXT; e++) begin : g_ext
    iso_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk      (clk),
      .rst      (rst),
      .async_in (ext_in[e]),
      .tick     (ext_tick[e])
    );
  end

  for (genvar d = 0; d < 2; d++) begin : g_dir
    always_comb begin
      case (dir_sel[d])
        CK_DCE_TX: dir_next[d] = ext_tick[0];
        CK_DCE_RX: dir_next[d] = ext_tick[1];
        default:   dir_next[d] = brg_tick[d];
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_tick <= 1'b0;
      rx_tick <= 1'b0;
      cfg_err <= 1'b0;
    end else begin
      tx_tick <= dir_next[0];
      rx_tick <= dir_next[1];
      cfg_err <= cfg_bad;
    end
  end

  assign silence = stop_clk & ((line_sel[0] != OUT_OFF) | (line_sel[1] != OUT_OFF));

  for (genvar l = 0; l < 2; l++) begin : g_line
    iso_timing_line u_line (
      .clk     (clk),
      .rst     (rst),
      .src     (line_sel[l]),
      .rx_brg  (rx_brg_tick),
      .tx_brg  (tx_brg_tick),
      .ext_tx  (ext_tick[0]),
      .ext_rx  (ext_tick[1]),
      .silence (silence),
      .line    (line_q[l]),
      .oe      (oe_q[l])
    );
  end

  assign dte_txt_out = line_q[0];
  assign dte_rxt_out = line_q[1];
  assign dte_txt_oe  = oe_q[0];
  assign dte_rxt_oe  = oe_q[1];

  // R9
  cfg_err_chk: assert property (@(posedge clk) disable iff (rst)
    (cfg_word[2:0] > 3'd2) |=> cfg_err);
  // R2
  tx_int_chk: assert property (@(posedge clk) disable iff (rst)
    (cfg_word[2:0] == 3'd0 && tx_brg_tick) |=> tx_tick);
  // R10
  async_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (cfg_word == '0) |=> (!dte_txt_oe && !dte_rxt_oe && !cfg_err));
endmodule

// File: tb/tb_iso_clk_router.sv
`timescale 1ns/1ps
module tb_iso_clk_router;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        rst;
  logic [11:0] cfg_word;
  logic        tx_brg_tick, rx_brg_tick, dce_txt_in, dce_rxt_in, stop_clk;
  logic        tx_tick, rx_tick, dte_txt_out, dte_txt_oe, dte_rxt_out, dte_rxt_oe, cfg_err;

  iso_clk_router dut (
    .clk(clk), .rst(rst), .cfg_word(cfg_word),
    .tx_brg_tick(tx_brg_tick), .rx_brg_tick(rx_brg_tick),
    .dce_txt_in(dce_txt_in), .dce_rxt_in(dce_rxt_in), .stop_clk(stop_clk),
    .tx_tick(tx_tick), .rx_tick(rx_tick),
    .dte_txt_out(dte_txt_out), .dte_txt_oe(dte_txt_oe),
    .dte_rxt_out(dte_rxt_out), .dte_rxt_oe(dte_rxt_oe), .cfg_err(cfg_err)
  );

  int checks = 0;
  int failures = 0;
  bit done = 0;

  // reference model state: history of external levels and expected outputs
  int h_tx[$];
  int h_rx[$];
  int e_tx, e_rx, e_err;
  int e_line[2];
  int e_oe[2];

  task automatic chk(input string tag, input logic act, input int exp, input string what);
    checks++;
    if (int'(act) != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d t=%0t", tag, what, act, exp, $time);
    end
  endtask

  function automatic int pick_out(input int code, input int rxb, input int txb, input int x1, input int x2);
    case (code)
      1: return rxb;
      2: return txb;
      3: return x1;
      4: return x2;
      default: return 0;
    endcase
  endfunction

  task automatic model_edge();
    int x1, x2, txc, rxc, oc[2], tk, stop_eff;
    if (rst) begin
      h_tx = {0, 0, 0};
      h_rx = {0, 0, 0};
      e_tx = 0; e_rx = 0; e_err = 0;
      for (int i = 0; i < 2; i++) begin e_line[i] = 0; e_oe[i] = 0; end
      return;
    end
    // tick seen at this edge: rise between two and three edges back
    x1 = (h_tx[1] == 1 && h_tx[2] == 0) ? 1 : 0;
    x2 = (h_rx[1] == 1 && h_rx[2] == 0) ? 1 : 0;
    h_tx.push_front(int'(dce_txt_in)); void'(h_tx.pop_back());
    h_rx.push_front(int'(dce_rxt_in)); void'(h_rx.pop_back());
    txc = cfg_word[2:0];
    rxc = cfg_word[5:3];
    oc[0] = cfg_word[8:6];
    oc[1] = cfg_word[11:9];
    e_err = (txc > 2 || rxc > 2 || oc[0] > 4 || oc[1] > 4) ? 1 : 0;
    if (txc > 2) txc = 0;
    if (rxc > 2) rxc = 0;
    for (int i = 0; i < 2; i++) if (oc[i] > 4) oc[i] = 0;
    e_tx = (txc == 1) ? x1 : (txc == 2) ? x2 : int'(tx_brg_tick);
    e_rx = (rxc == 1) ? x1 : (rxc == 2) ? x2 : int'(rx_brg_tick);
    stop_eff = (stop_clk && (oc[0] != 0 || oc[1] != 0)) ? 1 : 0;
    for (int i = 0; i < 2; i++) begin
      e_oe[i] = (oc[i] != 0) ? 1 : 0;
      tk = pick_out(oc[i], int'(rx_brg_tick), int'(tx_brg_tick), x1, x2);
      if (oc[i] == 0 || stop_eff == 1) e_line[i] = 0;
      else if (tk == 1) e_line[i] = 1 - e_line[i];
    end
  endtask

  task automatic compare_all();
    string td, tl;
    td = (cfg_word == 0) ? "R10" : (e_err == 1) ? "R9" : "";
    chk(td != "" ? td : (cfg_word[2:0] != 0 ? "R4" : "R2"), tx_tick, e_tx, "tx_tick");
    chk(td != "" ? td : (cfg_word[5:3] != 0 ? "R4" : "R3"), rx_tick, e_rx, "rx_tick");
    tl = stop_clk ? "R8" : td;
    chk(tl != "" ? tl : "R5", dte_txt_out, e_line[0], "dte_txt_out");
    chk(tl != "" ? tl : "R6", dte_rxt_out, e_line[1], "dte_rxt_out");
    chk("R7", dte_txt_oe, e_oe[0], "dte_txt_oe");
    chk("R7", dte_rxt_oe, e_oe[1], "dte_rxt_oe");
    chk("R9", cfg_err, e_err, "cfg_err");
  endtask

  // one cycle: inputs already driven after a falling edge
  task automatic cycle();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    compare_all();
  endtask

  task automatic run_phase(input logic [11:0] cfg, input int n, input int stop_mode, input int seed_ofs);
    cfg_word = cfg;
    for (int c = 0; c < n; c++) begin
      tx_brg_tick = ($urandom % 4) == 0;
      rx_brg_tick = ($urandom % 3) == 0;
      if ((c + seed_ofs) % 3 == 0) dce_txt_in = ~dce_txt_in;
      if ((c + seed_ofs) % 7 == 0) dce_rxt_in = ~dce_rxt_in;
      stop_clk = (stop_mode != 0) && ((c % 40) >= 10) && ((c % 40) < 18);
      cycle();
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int pulses;
    rst = 1'b1; cfg_word = 12'o0000; tx_brg_tick = 0; rx_brg_tick = 0;
    dce_txt_in = 0; dce_rxt_in = 0; stop_clk = 0;
    @(negedge clk);
    for (int i = 0; i < 4; i++) begin
      tx_brg_tick = 1; rx_brg_tick = 1; dce_txt_in = i[0]; cfg_word = 12'o4321;
      cycle();
    end
    // R1: outputs at reset
    chk("R1", tx_tick | rx_tick | cfg_err, 0, "tick/err in reset");
    chk("R1", dte_txt_out | dte_txt_oe | dte_rxt_out | dte_rxt_oe, 0, "lines in reset");
    rst = 1'b0; cfg_word = 12'o0000; tx_brg_tick = 0; rx_brg_tick = 0; dce_txt_in = 0;
    cycle();
    chk("R1", tx_tick | dte_txt_oe | dte_rxt_oe | cfg_err, 0, "first cycle after reset");

    run_phase(12'o0000, 200, 1, 0);   // R10 plain async, stop has no effect
    run_phase(12'o4321, 300, 0, 1);   // R2 R3 R5 R6 external and generator routing
    run_phase(12'o1212, 300, 1, 2);   // swapped sources with stop bursts (R8)
    run_phase(12'o0300, 200, 1, 3);   // one line driven, one off (R7)
    run_phase(12'o2000, 200, 0, 4);
    run_phase(12'o7677, 200, 1, 5);   // undefined codes (R9)
    run_phase(12'o5503, 200, 0, 6);
    run_phase(12'o0022, 200, 1, 0);

    // R4: a held-high level yields one tick only
    cfg_word = 12'o0001; stop_clk = 0; tx_brg_tick = 1; rx_brg_tick = 0;
    dce_txt_in = 0;
    for (int i = 0; i < 6; i++) cycle();
    pulses = 0;
    dce_txt_in = 1;
    for (int i = 0; i < 24; i++) begin
      cycle();
      if (tx_tick) pulses++;
    end
    checks++;
    if (pulses != 1) begin
      failures++;
      $display("FAIL R4 single tick actual=%0d expected=1", pulses);
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule